// File: doc/BRIEF.md
# Multi-mode timer/event counter

This block is a programmable up-counter that runs in one of three modes. In event mode it counts edges seen on an external pin. In timer mode it counts cycles in which an internal tick strobe is high. In pulse-width mode it counts ticks only while the external pin stays at its active level. It can be built 8 or 16 bits wide. Software controls it through a small register port: a control register that sets the mode, the run bit and the edge polarity, and a preload register. Reads return either the control byte or the live count.

When the count passes its all-ones value, the counter reloads from the preload register and raises a sticky request flag on `irq_o`. Software clears the flag by writing the control register. The external pin passes through a two-flop synchroniser, and edges are detected on the synchronised level. In pulse-width mode the run bit clears itself when the pin leaves its active level, so the count that remains is the pulse length in ticks.

Top module: `evt_timer`

## Requirements
- R1: After reset the control byte reads 0x00 (mode 00, stopped, rising polarity, flag clear), the count reads 0 and `irq_o` is low.
- R2: The mode is control bits [7:6]: 01 is event mode, 10 is timer mode, 11 is pulse-width mode. With 00 the count never changes, whatever the tick and pin do.
- R3: Control bit 4 is the run bit. While it is 0 the count changes only through a preload write.
- R4: In event mode the counter adds one for each active edge of the synchronised pin: rising when control bit 3 is 0, falling when it is 1. Edges of the other polarity are ignored.
- R5: In timer mode the counter adds one on each clock edge at which `tick_i` is high.
- R6: In pulse-width mode the counter adds one per tick while the synchronised pin is at its active level (high when bit 3 is 0, low when bit 3 is 1). When the pin leaves that level, the run bit clears itself and counting stops.
- R7: An increment taken from the all-ones value loads the preload value into the count and sets the flag. The flag is visible at control bit 0 and on `irq_o`.
- R8: The flag stays set until a control write with bit 0 = 1 clears it. A control write with bit 0 = 0 leaves it set. If an overflow happens in the same cycle as the clear, the flag stays set.
- R9: A write to select 1 stores the preload value. If the run bit is 0, the same write also loads the count. If the run bit is 1, the count is left unchanged.
- R10: The parameter `W` selects a counter width of 8 or 16 bits. The overflow point is the all-ones value of that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count strobe for timer and pulse-width modes |
| ext_i | input | 1 | External pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 is the control register, 1 is the preload register |
| wr_data_i | input | W | Write data; the control register uses bits [7:0] |
| rd_sel_i | input | 1 | Read select: 0 returns the control byte, 1 returns the count |
| rd_data_o | output | W | Read data, combinational from registered state |
| irq_o | output | 1 | Sticky overflow request |

## Verification
A register write takes effect at the clock edge that samples the strobe and can be read back by the next falling edge. A tick is counted at the edge that samples it. An external pin change is counted at the third rising edge after the pin change is first sampled, because of the two synchroniser stages and the edge-detect stage. In pulse-width mode the run bit drops one edge after the last counted tick. The bench drives every input on the falling edge and reads results on a later falling edge, after these latencies have passed. It also lets the synchroniser settle for four cycles before it changes mode or polarity, so no leftover edge is counted by mistake.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmode_e;

    localparam int CTL_W     = 8;
    localparam int MODE_LSB  = 6;
    localparam int RUN_BIT   = 4;
    localparam int POL_BIT   = 3;
    localparam int FLAG_BIT  = 0;

    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_CNT = 1'b1;

    typedef struct packed {
        tmode_e mode;
        logic   run;
        logic   pol_fall;
    } ctrl_t;

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         ovf_i,
    input  logic         pw_end_i,
    output ctrl_t        ctrl_o,
    output logic         flag_o,
    output logic [W-1:0] preload_o,
    output logic         load_o
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic         flag;
        logic [W-1:0] preload;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_ctl, wr_pre;

    always_comb begin
        wr_ctl = wr_en_i && (wr_sel_i == SEL_CTL);
        wr_pre = wr_en_i && (wr_sel_i == SEL_CNT);
        s_d    = s_q;
        if (pw_end_i) s_d.ctrl.run = 1'b0;
        if (wr_ctl) begin
            s_d.ctrl.mode     = tmode_e'(wr_data_i[MODE_LSB +: 2]);
            s_d.ctrl.run      = wr_data_i[RUN_BIT];
            s_d.ctrl.pol_fall = wr_data_i[POL_BIT];
            if (wr_data_i[FLAG_BIT]) s_d.flag = 1'b0;
        end
        if (wr_pre) s_d.preload = wr_data_i;
        if (ovf_i)  s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o    = s_q.ctrl;
    assign flag_o    = s_q.flag;
    assign preload_o = s_q.preload;
    assign load_o    = wr_pre && !s_q.ctrl.run;

endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt
    import evt_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctrl_t        ctrl_i,
    input  logic         tick_i,
    input  logic         lvl_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] preload_i,
    output logic [W-1:0] cnt_o,
    output logic         inc_o,
    output logic         ovf_o,
    output logic         pw_end_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic act_edge, act_lvl, leave;

    always_comb begin
        act_edge = ctrl_i.pol_fall ? fall_i : rise_i;
        act_lvl  = ctrl_i.pol_fall ? ~lvl_i : lvl_i;
        leave    = ctrl_i.pol_fall ? rise_i : fall_i;
        unique case (ctrl_i.mode)
            MODE_EVENT: inc_o = ctrl_i.run && act_edge;
            MODE_TIMER: inc_o = ctrl_i.run && tick_i;
            MODE_PULSE: inc_o = ctrl_i.run && tick_i && act_lvl;
            default:    inc_o = 1'b0;
        endcase
        pw_end_o = ctrl_i.run && (ctrl_i.mode == MODE_PULSE) && leave;
        ovf_o    = inc_o && (s_q.cnt == TOP);
        s_d      = s_q;
        if (load_i)     s_d.cnt = load_val_i;
        else if (ovf_o) s_d.cnt = preload_i;
        else if (inc_o) s_d.cnt = s_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int W       = 8,
    parameter int SYNC_FF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         ext_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_sel_i,
    output logic [W-1:0] rd_data_o,
    output logic         irq_o
);
    ctrl_t        ctrl_w;
    logic         flag_w, load_w, inc_w, ovf_w, pw_end_w;
    logic         lvl_w, rise_w, fall_w;
    logic [W-1:0] preload_w, cnt_w;
    logic [CTL_W-1:0] ctl_byte;

    evt_timer_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_i),
        .lvl_o  (lvl_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    evt_timer_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .ovf_i     (ovf_w),
        .pw_end_i  (pw_end_w),
        .ctrl_o    (ctrl_w),
        .flag_o    (flag_w),
        .preload_o (preload_w),
        .load_o    (load_w)
    );

    evt_timer_cnt #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl_w),
        .tick_i     (tick_i),
        .lvl_i      (lvl_w),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .load_i     (load_w),
        .load_val_i (wr_data_i),
        .preload_i  (preload_w),
        .cnt_o      (cnt_w),
        .inc_o      (inc_w),
        .ovf_o      (ovf_w),
        .pw_end_o   (pw_end_w)
    );

    always_comb begin
        ctl_byte = {ctrl_w.mode, 1'b0, ctrl_w.run, ctrl_w.pol_fall, 2'b00, flag_w};
        rd_data_o = (rd_sel_i == SEL_CNT) ? cnt_w : W'(ctl_byte);
    end

    assign irq_o = flag_w;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic [W-1:0] preload,
    input logic         inc,
    input logic         flag,
    input logic         run,
    input logic [1:0]   mode,
    input logic         wr_en,
    input logic         wr_sel,
    input logic         wr_d0,
    input logic         pw_end
);
    // R7
    ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == {W{1'b1}}) |=> (cnt == $past(preload) && flag));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != {W{1'b1}}) |=> (cnt == $past(cnt) + W'(1)));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && !wr_sel && wr_d0)) |=> flag);

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && wr_sel)) |=> $stable(cnt));

    // R2
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !(wr_en && wr_sel)) |=> $stable(cnt));

    // R6
    pw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_end && !(wr_en && !wr_sel)) |=> !run);

endmodule

bind evt_timer evt_timer_chk #(.W(W)) u_evt_timer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_w),
    .preload (preload_w),
    .inc     (inc_w),
    .flag    (flag_w),
    .run     (ctrl_w.run),
    .mode    (ctrl_w.mode),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_d0   (wr_data_i[0]),
    .pw_end  (pw_end_w)
);

// File: tb/test_evt_timer.sv
module test_evt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ext = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [7:0]  rd8;
    logic [15:0] rd16;
    logic        irq8, irq16;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    evt_timer #(.W(8)) i_evt_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_i(ext),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data[7:0]),
        .rd_sel_i(rd_sel), .rd_data_o(rd8), .irq_o(irq8)
    );

    evt_timer #(.W(16)) i_evt_timer_w16 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_i(ext),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd16), .irq_o(irq16)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       run;
        logic       fall;
        logic [7:0] pre;
        logic [7:0] n;
        logic [7:0] exp_cnt;
        logic       exp_flag;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'b10, 1'b1, 1'b0, 8'h00, 8'd5, 8'h05, 1'b0},
        '{2'b10, 1'b1, 1'b0, 8'hFE, 8'd3, 8'hFF, 1'b1},
        '{2'b01, 1'b1, 1'b0, 8'h10, 8'd4, 8'h14, 1'b0},
        '{2'b01, 1'b1, 1'b1, 8'hFD, 8'd4, 8'hFE, 1'b1},
        '{2'b00, 1'b1, 1'b0, 8'h33, 8'd6, 8'h33, 1'b0},
        '{2'b10, 1'b0, 1'b0, 8'h40, 8'd3, 8'h40, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v8, output logic [15:0] v16);
        @(negedge clk);
        rd_sel = sel;
        #1;
        v8 = rd8; v16 = rd16;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic ext_pulse(input logic fall);
        @(negedge clk); ext = ~fall;
        idle(2); ext = fall;
        idle(2);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_err++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
        end
    end

    initial begin
        logic [7:0]  v8;
        logic [15:0] v16;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(1'b0, v8, v16); check("R1 ctl", {8'h0, v8}, 16'h0000);
        rd(1'b1, v8, v16); check("R1 cnt", {8'h0, v8}, 16'h0000);
        check("R1 irq", {15'h0, irq8}, 16'h0000);

        // table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            ext = VEC[i].fall;
            tick = 1'b0;
            wr(1'b0, 16'h0001);
            idle(4);
            wr(1'b1, {8'h0, VEC[i].pre});
            wr(1'b0, {8'h0, VEC[i].mode, 1'b0, VEC[i].run, VEC[i].fall, 3'b000});
            for (int k = 0; k < VEC[i].n; k++) begin
                if (VEC[i].mode == 2'b01 || VEC[i].mode == 2'b00) ext_pulse(VEC[i].fall);
                if (VEC[i].mode == 2'b10 || VEC[i].mode == 2'b00) tick_pulse();
            end
            idle(4);
            rd(1'b1, v8, v16);
            check($sformatf("R2/R3/R4/R5/R7 vec%0d cnt", i), {8'h0, v8}, {8'h0, VEC[i].exp_cnt});
            check($sformatf("R7 vec%0d irq", i), {15'h0, irq8}, {15'h0, VEC[i].exp_flag});
        end

        // R9 preload write while running leaves count
        ext = 1'b0;
        wr(1'b0, 16'h0001); idle(4);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h0090);
        repeat (3) tick_pulse();
        wr(1'b1, 16'h00F0);
        rd(1'b1, v8, v16); check("R9 running", {8'h0, v8}, 16'h0003);
        wr(1'b0, 16'h0080);
        wr(1'b1, 16'h0020);
        rd(1'b1, v8, v16); check("R9 stopped load", {8'h0, v8}, 16'h0020);

        // R7 R8 overflow and flag clearing
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h00FF);
        wr(1'b0, 16'h0090);
        tick_pulse();
        rd(1'b1, v8, v16); check("R7 reload", {8'h0, v8}, 16'h00FF);
        check("R7 irq", {15'h0, irq8}, 16'h0001);
        wr(1'b0, 16'h0090);
        rd(1'b0, v8, v16); check("R8 bit0=0 keeps", {15'h0, v8[0]}, 16'h0001);
        wr(1'b0, 16'h0091);
        rd(1'b0, v8, v16); check("R8 bit0=1 clears", {15'h0, v8[0]}, 16'h0000);
        check("R8 irq low", {15'h0, irq8}, 16'h0000);

        // R6 pulse width, active high
        wr(1'b0, 16'h0001); ext = 1'b0; idle(4);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h00D0);
        @(negedge clk); tick = 1'b1;
        idle(3);
        ext = 1'b1;
        idle(7);
        ext = 1'b0;
        idle(5);
        rd(1'b1, v8, v16); check("R6 high width", {8'h0, v8}, 16'h0007);
        rd(1'b0, v8, v16); check("R6 run cleared", {15'h0, v8[4]}, 16'h0000);
        ext = 1'b1; idle(5); ext = 1'b0; idle(5);
        rd(1'b1, v8, v16); check("R6 stays stopped", {8'h0, v8}, 16'h0007);
        tick = 1'b0;

        // R6 pulse width, active low
        ext = 1'b1;
        wr(1'b0, 16'h0001); idle(4);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h00D8);
        @(negedge clk); tick = 1'b1;
        idle(2);
        ext = 1'b0;
        idle(4);
        ext = 1'b1;
        idle(5);
        tick = 1'b0;
        rd(1'b1, v8, v16); check("R6 low width", {8'h0, v8}, 16'h0004);

        // R10 16-bit width overflow
        ext = 1'b0;
        wr(1'b0, 16'h0001); idle(4);
        wr(1'b1, 16'hFFFE);
        wr(1'b0, 16'h0090);
        repeat (3) tick_pulse();
        rd(1'b1, v8, v16); check("R10 w16 cnt", v16, 16'hFFFF);
        check("R10 w16 irq", {15'h0, irq16}, 16'h0001);

        done = 1'b1;
        summary();
    end

endmodule